// File: doc/BRIEF.md
# Partition-Filtered Invalidation Snoop Acceptor

This block sits between a system bus and a translation-cache invalidation engine. Invalidation snoops arrive from the bus, and each one names a target logical partition with an 8-bit ID. For each snoop the block makes one of two choices. It can turn the snoop away at once with a one-cycle reject pulse. Or it can accept the snoop, hand an invalidation request to the engine, wait for the engine's done strobe, and then send a one-cycle complete pulse back toward the memory subsystem.

The accept rule depends on two controls. A mode bit selects translation-cache-only operation or full-MMU operation, and a reject-enable bit matters only in full-MMU mode. In cache-only mode, a snoop is accepted only when its partition matches the local partition register. In full-MMU mode with reject-enable clear, every snoop is accepted, and the snoop's own partition ID becomes the match key. In full-MMU mode with reject-enable set, the partition must match, as in cache-only mode.

A flag on the request tells the engine to clear the main TLB copy as well as the cache copy. Only one snoop is handled at a time: the ready output stays low until the current snoop is finished.

Top module: `inval_snoop_filter`

## Requirements
- R1: After reset the block is idle: `snp_ready`=1, and `rej_pulse`, `cmp_pulse` and `inv_req` are all 0.
- R2: With `cache_only`=1, a snoop whose `snp_pid` differs from `local_pid` produces `rej_pulse`=1 for exactly one cycle, in the cycle after the snoop is sampled. It raises no `inv_req` and no `cmp_pulse`, and `snp_ready` returns to 1 in the following cycle.
- R3: With `cache_only`=1, a snoop whose `snp_pid` equals `local_pid` is accepted. In the cycle after sampling, `inv_req`=1, `inv_pid` equals the snoop's ID, and `inv_tlb`=0, which means only the cache copy is cleared.
- R4: With `cache_only`=0 and `rej_en`=0, every snoop is accepted whatever `local_pid` holds. `inv_pid` carries the snoop's own ID, `inv_tlb`=1, and `rej_pulse` never rises.
- R5: With `cache_only`=0 and `rej_en`=1, a mismatching snoop is rejected exactly as in R2, and a matching snoop is accepted with `inv_tlb`=1.
- R6: When `inv_done` is seen while `inv_req`=1, `inv_req` falls and `cmp_pulse`=1 for exactly one cycle in the next cycle. No `cmp_pulse` occurs before `inv_done`.
- R7: `snp_ready` is 0 from the cycle after sampling until the reject or complete pulse has ended. A `snp_valid` presented while `snp_ready`=0 is ignored.
- R8: `inv_done` arriving while no request is pending is ignored and produces no `cmp_pulse`.
- R9: `inv_pid` and `inv_tlb` hold the values captured at sampling, even if `snp_pid`, `local_pid`, `cache_only` or `rej_en` change while the request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snoop present on the bus |
| snp_pid | input | 8 | Target partition ID of the snoop |
| snp_ready | output | 1 | Block can take a snoop this cycle |
| cache_only | input | 1 | 1: translation-cache-only mode, 0: full-MMU mode |
| rej_en | input | 1 | Reject foreign-partition snoops in full-MMU mode |
| local_pid | input | 8 | Local partition register |
| inv_req | output | 1 | Invalidation request to the engine, held until done |
| inv_pid | output | 8 | Partition ID the engine must match on |
| inv_tlb | output | 1 | 1: clear the main TLB copy as well as the cache copy |
| inv_done | input | 1 | Engine finished the invalidation |
| rej_pulse | output | 1 | One-cycle reject indication |
| cmp_pulse | output | 1 | One-cycle completion indication |

## Verification
Snoops are sent with matching and with mismatching partition IDs in each of the three control settings: cache-only, full-MMU with reject-enable clear, and full-MMU with reject-enable set. Each setting shows a different split between reject and accept. In the full-MMU, reject-enable-clear setting, a foreign partition ID shows whether the request carries the snoop's ID or the local one. Other runs use a delayed done strobe, a stray done strobe, a snoop presented while busy, and controls changed during a pending request. These runs separate the completion timing from the ready and holding behaviour.

// File: rtl/inval_snoop_filter.sv
module inval_snoop_filter #(
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  logic [PID_W-1:0] snp_pid,
  output logic             snp_ready,
  input  logic             cache_only,
  input  logic             rej_en,
  input  logic [PID_W-1:0] local_pid,
  output logic             inv_req,
  output logic [PID_W-1:0] inv_pid,
  output logic             inv_tlb,
  input  logic             inv_done,
  output logic             rej_pulse,
  output logic             cmp_pulse
);

  typedef enum logic [1:0] {S_IDLE, S_REJ, S_WAIT, S_CMP} state_t;

  state_t state, state_nx;
  logic   take;
  logic   foreign;
  logic   refuse;

  assign take    = snp_valid && snp_ready;
  assign foreign = snp_pid != local_pid;
  assign refuse  = foreign && (cache_only || rej_en);

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:  if (take) state_nx = refuse ? S_REJ : S_WAIT;
      S_REJ:   state_nx = S_IDLE;
      S_WAIT:  if (inv_done) state_nx = S_CMP;
      S_CMP:   state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      inv_pid <= '0;
      inv_tlb <= 1'b0;
    end else begin
      state <= state_nx;
      if (take && !refuse) begin
        inv_pid <= snp_pid;
        inv_tlb <= !cache_only;
      end
    end
  end

  assign snp_ready = state == S_IDLE;
  assign inv_req   = state == S_WAIT;
  assign rej_pulse = state == S_REJ;
  assign cmp_pulse = state == S_CMP;

endmodule

module inval_snoop_filter_chk #(
  parameter int PID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             snp_valid,
  input logic [PID_W-1:0] snp_pid,
  input logic             snp_ready,
  input logic             cache_only,
  input logic             rej_en,
  input logic [PID_W-1:0] local_pid,
  input logic             inv_req,
  input logic [PID_W-1:0] inv_pid,
  input logic             inv_tlb,
  input logic             inv_done,
  input logic             rej_pulse,
  input logic             cmp_pulse
);

  p_rej_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |=> !rej_pulse);

  p_rej_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |-> $past(snp_valid && snp_ready && (snp_pid != local_pid) && (cache_only || rej_en)));

  p_no_rej_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_ready && !cache_only && !rej_en) |=> !rej_pulse);

  p_cmp_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |-> $past(inv_done && inv_req));

  p_cmp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);

  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req || rej_pulse || cmp_pulse) |-> !snp_ready);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && $past(inv_req)) |-> ($stable(inv_pid) && $stable(inv_tlb)));

  p_accept_scope_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_req) |-> (inv_tlb == !$past(cache_only)) && (inv_pid == $past(snp_pid)));

endmodule

bind inval_snoop_filter inval_snoop_filter_chk #(.PID_W(PID_W)) u_chk (.*);

// File: tb/inval_snoop_filter_test.sv
module inval_snoop_filter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       snp_valid = 0;
  logic [7:0] snp_pid = 0;
  logic       snp_ready;
  logic       cache_only = 0;
  logic       rej_en = 0;
  logic [7:0] local_pid = 0;
  logic       inv_req;
  logic [7:0] inv_pid;
  logic       inv_tlb;
  logic       inv_done = 0;
  logic       rej_pulse;
  logic       cmp_pulse;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inval_snoop_filter uut (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] pid);
    snp_valid = 1; snp_pid = pid;
    step();
    snp_valid = 0;
  endtask

  task automatic expect_reject(string tag, input logic [7:0] pid);
    send(pid);
    check({tag, " rej_pulse"}, rej_pulse, 1);
    check({tag, " inv_req"}, inv_req, 0);
    check({tag, " ready low"}, snp_ready, 0);
    step();
    check({tag, " rej one cycle"}, rej_pulse, 0);
    check({tag, " no cmp"}, cmp_pulse, 0);
    check({tag, " ready back"}, snp_ready, 1);
  endtask

  task automatic expect_accept(string tag, input logic [7:0] pid, input bit tlb, input int delay);
    send(pid);
    check({tag, " inv_req"}, inv_req, 1);
    check({tag, " inv_pid"}, inv_pid, pid);
    check({tag, " inv_tlb"}, inv_tlb, tlb);
    check({tag, " no rej"}, rej_pulse, 0);
    for (int i = 0; i < delay; i++) begin
      step();
      check({tag, " R6 no early cmp"}, cmp_pulse, 0);
      check({tag, " R7 busy"}, snp_ready, 0);
    end
    inv_done = 1;
    step();
    inv_done = 0;
    check({tag, " R6 cmp"}, cmp_pulse, 1);
    check({tag, " R6 req drop"}, inv_req, 0);
    step();
    check({tag, " R6 cmp one cycle"}, cmp_pulse, 0);
    check({tag, " ready back"}, snp_ready, 1);
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step(); rst_n = 1; step();
    check("R1 ready", snp_ready, 1);
    check("R1 rej", rej_pulse, 0);
    check("R1 cmp", cmp_pulse, 0);
    check("R1 req", inv_req, 0);
  endtask

  task automatic t_cache_only();
    cache_only = 1; rej_en = 0; local_pid = 8'h3C;
    expect_reject("R2 cache mismatch", 8'h3D);
    expect_accept("R3 cache match", 8'h3C, 0, 2);
  endtask

  task automatic t_full_open();
    cache_only = 0; rej_en = 0; local_pid = 8'h10;
    expect_accept("R4 foreign pid", 8'hA7, 1, 0);
    expect_accept("R4 local pid", 8'h10, 1, 3);
  endtask

  task automatic t_full_strict();
    cache_only = 0; rej_en = 1; local_pid = 8'h55;
    expect_reject("R5 mismatch", 8'hFF);
    expect_accept("R5 match", 8'h55, 1, 1);
  endtask

  task automatic t_busy_ignore();
    cache_only = 1; local_pid = 8'h22;
    send(8'h22);
    snp_valid = 1; snp_pid = 8'h99;
    step();
    snp_valid = 0;
    check("R7 ignored no rej", rej_pulse, 0);
    check("R7 still pending", inv_req, 1);
    check("R7 pid kept", inv_pid, 8'h22);
    inv_done = 1; step(); inv_done = 0;
    check("R7 cmp", cmp_pulse, 1);
    step();
    check("R7 idle", snp_ready, 1);
    check("R7 no late rej", rej_pulse, 0);
  endtask

  task automatic t_stray_done();
    inv_done = 1; step(); inv_done = 0;
    check("R8 no cmp", cmp_pulse, 0);
    step();
    check("R8 no cmp later", cmp_pulse, 0);
    check("R8 ready", snp_ready, 1);
  endtask

  task automatic t_hold();
    cache_only = 1; rej_en = 0; local_pid = 8'h44;
    send(8'h44);
    cache_only = 0; rej_en = 1; local_pid = 8'h01; snp_pid = 8'hEE;
    step();
    check("R9 pid held", inv_pid, 8'h44);
    check("R9 tlb held", inv_tlb, 0);
    inv_done = 1; step(); inv_done = 0;
    check("R9 cmp", cmp_pulse, 1);
    step();
  endtask

  initial begin
    t_reset();
    t_cache_only();
    t_full_open();
    t_full_strict();
    t_busy_ignore();
    t_stray_done();
    t_hold();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done_flag) begin
      done_flag = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule